// File: doc/BRIEF.md
# Serial/Parallel Delay Address Programming Port

This block is the control front end of a programmable delay element. It holds the active delay address, an 8-bit value by default, that the downstream delay stage uses. The address can be written in three ways, chosen by a mode pin and a single enable pin. In transparent parallel operation the parallel bus follows straight through to the active address. In latched parallel operation the bus is captured when enable falls. In serial operation the address is shifted in MSB first on rising serial-clock edges and applied when enable falls.

All pins are sampled on a system clock. Serial clock and enable edges are found by comparing each sample with the previous one. The serial output always carries the top bit of the shift register, so a write also reads back the old contents, and that read destroys them. Several units can be chained by connecting each serial output to the next unit's serial input. A separate output-enable models the high-impedance state of the serial output. A one-cycle update strobe tells the delay stage that the address has changed, so it can begin settling.

Top module: `dly_prog_port`

## Requirements
- R1: After reset, delayAddr is 0, updateStrobe is 0 and serOutEn is 0.
- R2: With modeSel=1 and enable high, delayAddr equals parBus one clock after each sample and follows every change of parBus.
- R3: With modeSel=1, the clock that sees enable fall loads the parBus value sampled in that same clock; while enable stays low, parBus changes leave delayAddr unchanged.
- R4: With modeSel=0 and enable high, each rising serClk edge shifts serIn into bit 0 of the shift register while the other bits move up one place; delayAddr does not change while enable is high.
- R5: With modeSel=0, the clock that sees enable fall copies the shift register into delayAddr.
- R6: With modeSel=0, once enable has been seen high, serOutData shows shift-register bit 7. After each rising serClk edge it shows the next lower old bit, so 8 edges read out the old byte MSB first.
- R7: Readback is destructive: after a frame, the shift register holds the written bits, and a following frame reads those back rather than the earlier contents.
- R8: Two chained units that receive 16 bits in one enable window end with the first byte in the far unit and the second byte in the near unit.
- R9: serOutEn is 1 only in the clock after enable was sampled high in serial mode; otherwise it is 0, which stands for high impedance.
- R10: serClk edges while enable is low do not change the shift register.
- R11: updateStrobe is high for exactly one clock, in the clock in which delayAddr shows a new value that differs from the previous one. It stays low otherwise, including when a load repeats the same value.
- R12: parBus[7] is the MSB and parBus[0] the LSB, matching the first and last serial bits, so the same value loaded either way gives the same delayAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all pins are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 1 = parallel loading, 0 = serial loading |
| enable | input | 1 | Load strobe, transparent control, or serial frame window |
| serClk | input | 1 | Serial shift clock; a rising level change counts as an edge |
| serIn | input | 1 | Serial data input |
| parBus | input | ADDR_W | Parallel address bus, bit ADDR_W-1 is the MSB |
| serOutData | output | 1 | Serial data output, bit ADDR_W-1 of the shift register |
| serOutEn | output | 1 | Serial output drive enable; 0 means high impedance |
| delayAddr | output | ADDR_W | Active delay address passed to the delay stage |
| updateStrobe | output | 1 | One-clock pulse when delayAddr changes |

## Verification
The bench builds two units at the default ADDR_W of 8 and wires the serial output of the first unit into the serial input of the second. This makes the 16-bit cascade frame observable. With this width, every serial frame can be read back through the ports and compared bit for bit. Random byte values from a fixed seed are mixed over all three loading modes. This brings repeated-value loads and unchanged-value strobes within reach, together with the bit ordering across the parallel and serial paths.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;
  typedef struct packed {
    logic shiftStb;
    logic commitSer;
    logic loadPar;
  } ctrlStb_t;
endpackage

// File: rtl/dly_prog_ctrl.sv
module dly_prog_ctrl
  import dly_prog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     modeSel,
  input  logic     enable,
  input  logic     serClk,
  output ctrlStb_t stb,
  output logic     serOutEn
);
  logic enQ, sckQ, modeQ;
  logic enFall, sckRise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ   <= 1'b0;
      sckQ  <= 1'b0;
      modeQ <= 1'b0;
    end else begin
      enQ   <= enable;
      sckQ  <= serClk;
      modeQ <= modeSel;
    end
  end

  assign enFall  = enQ & ~enable;
  assign sckRise = serClk & ~sckQ;

  // Mode decode: serial shifts only inside the enable window
  always_comb begin
    stb.shiftStb  = ~modeSel & enable & sckRise;
    stb.commitSer = ~modeSel & enFall;
    stb.loadPar   = modeSel & (enable | enFall);
  end

  assign serOutEn = enQ & ~modeQ;
endmodule

// File: rtl/dly_prog_dp.sv
module dly_prog_dp
  import dly_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStb_t          stb,
  input  logic              serIn,
  input  logic [ADDR_W-1:0] parBus,
  output logic [ADDR_W-1:0] delayAddr,
  output logic              updateStrobe,
  output logic              serOutBit
);
  localparam int MSB = ADDR_W - 1;

  logic [ADDR_W-1:0] shiftReg;
  logic [ADDR_W-1:0] nextAddr;
  logic              loadAny;

  always_ff @(posedge clk) begin
    if (!rst_n) shiftReg <= '0;
    else if (stb.shiftStb) shiftReg <= {shiftReg[MSB-1:0], serIn};
  end

  always_comb begin
    loadAny  = stb.commitSer | stb.loadPar;
    nextAddr = stb.commitSer ? shiftReg : parBus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delayAddr    <= '0;
      updateStrobe <= 1'b0;
    end else begin
      updateStrobe <= loadAny && (nextAddr != delayAddr);
      if (loadAny) delayAddr <= nextAddr;
    end
  end

  assign serOutBit = shiftReg[MSB];
endmodule

// File: rtl/dly_prog_port.sv
module dly_prog_port
  import dly_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeSel,
  input  logic              enable,
  input  logic              serClk,
  input  logic              serIn,
  input  logic [ADDR_W-1:0] parBus,
  output logic              serOutData,
  output logic              serOutEn,
  output logic [ADDR_W-1:0] delayAddr,
  output logic              updateStrobe
);
  ctrlStb_t stb;

  dly_prog_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .modeSel  (modeSel),
    .enable   (enable),
    .serClk   (serClk),
    .stb      (stb),
    .serOutEn (serOutEn)
  );

  dly_prog_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .serIn        (serIn),
    .parBus       (parBus),
    .delayAddr    (delayAddr),
    .updateStrobe (updateStrobe),
    .serOutBit    (serOutData)
  );
endmodule

// File: rtl/dly_prog_port_chk.sv
module dly_prog_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeSel,
  input logic              enable,
  input logic              serOutEn,
  input logic [ADDR_W-1:0] delayAddr,
  input logic              updateStrobe
);
  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !serOutEn);

  // R9
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeSel |=> !serOutEn);

  // R11
  strobe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updateStrobe |-> (delayAddr != $past(delayAddr)));

  // R11
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updateStrobe |-> $stable(delayAddr));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable ##1 !enable) |=> !updateStrobe);
endmodule

bind dly_prog_port dly_prog_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .modeSel      (modeSel),
  .enable       (enable),
  .serOutEn     (serOutEn),
  .delayAddr    (delayAddr),
  .updateStrobe (updateStrobe)
);

// File: tb/dly_prog_port_test.sv
module dly_prog_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic modeSel = 0, enable = 0, serClk = 0, serIn = 0;
  logic [W-1:0] parBus = '0;
  logic serOutData, serOutEn, updateStrobe;
  logic [W-1:0] delayAddr;
  logic serOut2, serOutEn2, updateStrobe2;
  logic [W-1:0] delayAddr2;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expAddr = '0;
  logic [W-1:0] expShift = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_prog_port #(.ADDR_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .enable(enable),
    .serClk(serClk), .serIn(serIn), .parBus(parBus),
    .serOutData(serOutData), .serOutEn(serOutEn),
    .delayAddr(delayAddr), .updateStrobe(updateStrobe));

  dly_prog_port #(.ADDR_W(W)) uut2 (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .enable(enable),
    .serClk(serClk), .serIn(serOutData), .parBus(parBus),
    .serOutData(serOut2), .serOutEn(serOutEn2),
    .delayAddr(delayAddr2), .updateStrobe(updateStrobe2));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expStrobe(input logic [W-1:0] oldV, input logic [W-1:0] newV);
    return oldV != newV;
  endfunction

  // Serial frame: writes val, returns the bits read out before each shift
  task automatic serialFrame(input logic [W-1:0] val, output logic [W-1:0] rd);
    modeSel = 0; enable = 1; serClk = 0;
    tick();
    check(serOutEn == 1'b1, "R9 oe in frame", serOutEn, 1);
    for (int i = W-1; i >= 0; i--) begin
      rd[i] = serOutData;
      serIn = val[i]; serClk = 1;
      tick();
      serClk = 0;
      tick();
    end
    check(delayAddr == expAddr, "R4 no change while enable high", delayAddr, expAddr);
    enable = 0;
    tick();
    check(delayAddr == val, "R5 serial commit", delayAddr, val);
    check(updateStrobe == expStrobe(expAddr, val), "R11 strobe on serial commit",
          updateStrobe, expStrobe(expAddr, val));
    expAddr = val;
    tick();
    check(updateStrobe == 1'b0, "R11 strobe single cycle", updateStrobe, 0);
    check(serOutEn == 1'b0, "R9 oe low after frame", serOutEn, 0);
  endtask

  task automatic serialCheck(input logic [W-1:0] val);
    logic [W-1:0] rd;
    serialFrame(val, rd);
    check(rd == expShift, "R6 R7 readback of old bits", rd, expShift);
    expShift = val;
  endtask

  task automatic transparent(input logic [W-1:0] val);
    modeSel = 1; enable = 1; parBus = val;
    tick();
    check(delayAddr == val, "R2 transparent load", delayAddr, val);
    check(updateStrobe == expStrobe(expAddr, val), "R11 strobe transparent",
          updateStrobe, expStrobe(expAddr, val));
    check(serOutEn == 1'b0, "R9 oe low in parallel", serOutEn, 0);
    expAddr = val;
  endtask

  task automatic latched(input logic [W-1:0] during, input logic [W-1:0] atFall,
                         input logic [W-1:0] after);
    transparent(during);
    enable = 0; parBus = atFall;
    tick();
    check(delayAddr == atFall, "R3 capture on enable fall", delayAddr, atFall);
    check(updateStrobe == expStrobe(expAddr, atFall), "R11 strobe latched",
          updateStrobe, expStrobe(expAddr, atFall));
    expAddr = atFall;
    parBus = after;
    tick(); tick();
    check(delayAddr == expAddr, "R3 bus ignored while enable low", delayAddr, expAddr);
    check(updateStrobe == 1'b0, "R11 no strobe when idle", updateStrobe, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    // R1 reset state
    check(delayAddr == '0, "R1 reset addr", delayAddr, 0);
    check(updateStrobe == 1'b0, "R1 reset strobe", updateStrobe, 0);
    check(serOutEn == 1'b0, "R1 reset oe", serOutEn, 0);
    rst_n = 1;
    tick();

    // R4 R5 R6 directed serial
    serialCheck(8'hA5);
    serialCheck(8'h3C);
    serialCheck(8'h3C);   // R11 same value, no strobe

    // R10 serial clock ignored while enable low
    modeSel = 0; enable = 0;
    for (int k = 0; k < 6; k++) begin
      serIn = k[0]; serClk = ~serClk;
      tick();
    end
    serClk = 0; tick();
    check(delayAddr == expAddr, "R10 addr unchanged", delayAddr, expAddr);
    serialCheck(8'h81);   // readback proves shift register kept 3C (R10)

    // R2 transparent tracking
    transparent(8'h12);
    transparent(8'hFE);
    transparent(8'hFE);
    // R3 latched pulse
    latched(8'h40, 8'h07, 8'hFF);

    // R12 same value via serial and parallel
    serialCheck(8'h96);
    transparent(8'h01);
    transparent(8'h96);
    check(delayAddr == 8'h96, "R12 bit mapping", delayAddr, 8'h96);
    enable = 0; tick();

    // R8 cascade of two units, 16 bits in one window
    begin
      logic [2*W-1:0] frame;
      frame = 16'hC3_5A;
      modeSel = 0; enable = 1; serClk = 0;
      tick();
      for (int i = 2*W-1; i >= 0; i--) begin
        serIn = frame[i]; serClk = 1; tick();
        serClk = 0; tick();
      end
      enable = 0; tick();
      check(delayAddr2 == 8'hC3, "R8 far unit gets first byte", delayAddr2, 8'hC3);
      check(delayAddr == 8'h5A, "R8 near unit gets second byte", delayAddr, 8'h5A);
      expAddr = 8'h5A; expShift = 8'h5A;
      tick();
    end

    // Random mix of modes
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, b, c;
      a = W'($urandom); b = W'($urandom); c = W'($urandom);
      if ($urandom_range(0, 3) == 0) b = expAddr;
      case ($urandom_range(0, 2))
        0: serialCheck(b);
        1: begin transparent(a); transparent(b); enable = 0; parBus = b; tick(); end
        default: latched(a, b, c);
      endcase
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule